// File: doc/BRIEF.md
# Configurable I/O Pad Control with Retention Hold

This block is the digital control model for one general-purpose I/O pad. The core supplies the output data, an active-low output enable, an open-drain select, a 2-bit drive-strength code and weak pull enables. From these the block resolves what the pad does: drive high, drive low, or float. It reports the strength in use, the pull direction and a pull-conflict flag. It also returns the pad level to the core.

A power controller supplies two further controls. The first is a second output enable, which gates every driver. The second is a retention strobe. When the strobe rises, the block freezes all core-side settings. The power-controller enable is not frozen and keeps acting live. Chip reset forces the driver to float. The power controller raises its enable only after its power-up pull-resistor sensing has finished, so user pads float until software configures them.

The control path is a three-state machine clocked by `clk`:
- **ST_RST** is held while `rst_n` is low and for the first clock after release.
- **ST_LIVE** follows the core inputs.
- **ST_HOLD** uses the captured settings.

The transitions are:
- **ST_RST → ST_LIVE** when the strobe is low at the release edge.
- **ST_RST → ST_HOLD** when the strobe is high at that edge. The live settings are captured.
- **ST_LIVE → ST_HOLD** when the strobe is sampled high. The live settings are captured.
- **ST_HOLD → ST_LIVE** when the strobe is sampled low.
- **any → ST_RST** when `rst_n` is asserted (asynchronous).

Top module: `pad_ctl_ret`

## Requirements
- R1: The pad drives (pad_state 01 or 10) only when core_oe_n is 0 and pwr_oe is 1 in the effective settings. Otherwise pad_state is 00 (high impedance). Code 11 never appears.
- R2: When driving with open-drain select 0, data 1 gives pad_state 10 and data 0 gives 01. With open-drain select 1, data 1 gives 00 and data 0 gives 01.
- R3: drv_eff equals the effective 2-bit strength code while pad_state is not 00. It is 00 while the pad floats. Bit 0 is the 2 mA stage and bit 1 is the 4 mA stage.
- R4: pull_dir is 10 for pullup only, 01 for pulldown only and 00 for neither. This holds regardless of both output enables, the strength code and reset.
- R5: When both pull enables are effective, pull_conflict is 1 and pull_dir is 11. Otherwise pull_conflict is 0.
- R6: At the first clock edge where ret_stb is sampled high, the core-side settings are captured. While the block is held, changes on the core inputs have no effect on any output.
- R7: pwr_oe is never captured. Lowering it during the hold floats the pad at once, and raising it restores the held drive.
- R8: While rst_n is low, and until the first clock edge after its release, pad_state is 00 and drv_eff is 00, whatever the core inputs are. Pulls still follow the core inputs.
- R9: The block follows the live core inputs again from the first clock edge where ret_stb is sampled low. Before that edge it keeps the held values.
- R10: core_din is 1 when the pad drives high and 0 when it drives low. When the pad floats, core_din is 1 with pullup only and 0 with pulldown only. It is undefined when the pad floats with no pull or with conflicting pulls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| core_dout | input | 1 | Output data from the core |
| core_oe_n | input | 1 | Core output enable, active low |
| core_od | input | 1 | Open-drain select |
| core_drv | input | 2 | Strength code: bit 0 is the 2 mA stage, bit 1 is the 4 mA stage |
| core_pu | input | 1 | Weak pullup enable |
| core_pd | input | 1 | Weak pulldown enable |
| pwr_oe | input | 1 | Power-controller output enable, active high, never held |
| ret_stb | input | 1 | Retention strobe |
| pad_state | output | 2 | 00 float, 01 drive low, 10 drive high, 11 reserved |
| drv_eff | output | 2 | Strength code in use, 00 when floating |
| pull_dir | output | 2 | 00 none, 01 down, 10 up, 11 conflict |
| pull_conflict | output | 1 | Both pulls enabled |
| core_din | output | 1 | Pad level returned to the core |

## Verification
The hardest case to reach is the hold window. It needs the strobe rising at a clock edge, different core inputs arriving afterwards, and the live power-controller enable toggling while the settings stay frozen. The bench captures a known driving setting and then applies an opposite setting on the core side. It checks that the outputs still reflect the captured values. It then pulses pwr_oe and drops the strobe, checking both before and after the edge at which the live inputs take over. The bench also sweeps all 256 combinations of the live inputs, plus a reset window in which the core requests drive.

// File: rtl/pad_ctl_pkg.sv
package pad_ctl_pkg;
    localparam int DRV_W = 2;

    typedef enum logic [1:0] {
        PAD_Z   = 2'b00,
        PAD_LO  = 2'b01,
        PAD_HI  = 2'b10,
        PAD_RSV = 2'b11
    } pad_st_e;

    typedef enum logic [1:0] {
        ST_RST  = 2'b00,
        ST_LIVE = 2'b01,
        ST_HOLD = 2'b10
    } hold_st_e;

    typedef struct packed {
        logic             od;
        logic [DRV_W-1:0] drv;
        logic             pu;
        logic             pd;
        logic             dout;
        logic             oe_n;
    } pad_cfg_t;
endpackage

// File: rtl/pad_cfg_hold.sv
module pad_cfg_hold
    import pad_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ret,
    input  pad_cfg_t live,
    output pad_cfg_t eff,
    output logic     in_rst
);
    hold_st_e st, st_nx;
    pad_cfg_t held;
    logic     capture;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RST:  st_nx = ret ? ST_HOLD : ST_LIVE;
            ST_LIVE: if (ret) st_nx = ST_HOLD;
            ST_HOLD: if (!ret) st_nx = ST_LIVE;
            default: st_nx = ST_RST;
        endcase
    end

    assign capture = ret && (st != ST_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_RST;
            held <= '{od: 1'b0, drv: '0, pu: 1'b0, pd: 1'b0, dout: 1'b0, oe_n: 1'b1};
        end else begin
            st <= st_nx;
            if (capture) held <= live;
        end
    end

    always_comb begin
        unique case (st)
            ST_HOLD: begin eff = held; in_rst = 1'b0; end
            ST_LIVE: begin eff = live; in_rst = 1'b0; end
            default: begin eff = live; in_rst = 1'b1; end
        endcase
    end

    // R6: captured settings do not move while the hold persists
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && $past(st) == ST_HOLD) |-> $stable(held));
endmodule

// File: rtl/pad_drive_resolve.sv
module pad_drive_resolve
    import pad_ctl_pkg::*;
(
    input  pad_cfg_t         cfg,
    input  logic             pwr_oe,
    input  logic             block,
    output pad_st_e          pad_st,
    output logic [DRV_W-1:0] drv_eff,
    output logic [1:0]       pull_dir,
    output logic             conflict,
    output logic             rx
);
    logic drive_on;

    assign drive_on = !cfg.oe_n && pwr_oe && !block;

    always_comb begin
        if (!drive_on)     pad_st = PAD_Z;
        else if (!cfg.dout) pad_st = PAD_LO;
        else if (cfg.od)    pad_st = PAD_Z;
        else                pad_st = PAD_HI;
    end

    assign drv_eff  = (pad_st != PAD_Z) ? cfg.drv : '0;
    assign pull_dir = {cfg.pu, cfg.pd};
    assign conflict = cfg.pu && cfg.pd;

    always_comb begin
        unique case (pad_st)
            PAD_HI:  rx = 1'b1;
            PAD_LO:  rx = 1'b0;
            default: begin
                if (cfg.pu && !cfg.pd)      rx = 1'b1;
                else if (cfg.pd && !cfg.pu) rx = 1'b0;
                else                        rx = 1'bx;
            end
        endcase
    end
endmodule

// File: rtl/pad_ctl_ret.sv
module pad_ctl_ret
    import pad_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_dout,
    input  logic       core_oe_n,
    input  logic       core_od,
    input  logic [1:0] core_drv,
    input  logic       core_pu,
    input  logic       core_pd,
    input  logic       pwr_oe,
    input  logic       ret_stb,
    output logic [1:0] pad_state,
    output logic [1:0] drv_eff,
    output logic [1:0] pull_dir,
    output logic       pull_conflict,
    output logic       core_din
);
    pad_cfg_t live_cfg, eff_cfg;
    logic     in_rst;
    pad_st_e  pad_st;

    assign live_cfg = '{od: core_od, drv: core_drv, pu: core_pu, pd: core_pd,
                        dout: core_dout, oe_n: core_oe_n};

    pad_cfg_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .ret    (ret_stb),
        .live   (live_cfg),
        .eff    (eff_cfg),
        .in_rst (in_rst)
    );

    pad_drive_resolve u_res (
        .cfg      (eff_cfg),
        .pwr_oe   (pwr_oe),
        .block    (in_rst || !rst_n),
        .pad_st   (pad_st),
        .drv_eff  (drv_eff),
        .pull_dir (pull_dir),
        .conflict (pull_conflict),
        .rx       (core_din)
    );

    assign pad_state = pad_st;

    assert_drive_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_st != PAD_Z) |-> (!eff_cfg.oe_n && pwr_oe));
    assert_no_rsv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pad_st != PAD_RSV);
    assert_od_no_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eff_cfg.od |-> (pad_st != PAD_HI));
    assert_pwr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_oe |-> (pad_state == 2'b00));
    assert_pullup_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_st == PAD_Z && pull_dir == 2'b10) |-> core_din);
endmodule

// File: tb/pad_ctl_ret_tb_top.sv
`timescale 1ns/1ps
module pad_ctl_ret_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_dout, core_oe_n, core_od, core_pu, core_pd, pwr_oe, ret_stb;
    logic [1:0] core_drv;
    logic [1:0] pad_state, drv_eff, pull_dir;
    logic pull_conflict, core_din;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pad_ctl_ret dut_i (
        .clk(clk), .rst_n(rst_n), .core_dout(core_dout), .core_oe_n(core_oe_n),
        .core_od(core_od), .core_drv(core_drv), .core_pu(core_pu), .core_pd(core_pd),
        .pwr_oe(pwr_oe), .ret_stb(ret_stb), .pad_state(pad_state), .drv_eff(drv_eff),
        .pull_dir(pull_dir), .pull_conflict(pull_conflict), .core_din(core_din)
    );

    // c = {oe_n, od, drv[1], drv[0], pu, pd, dout}
    task automatic apply(input logic [6:0] c, input logic pwr);
        {core_oe_n, core_od, core_drv, core_pu, core_pd, core_dout} = c;
        pwr_oe = pwr;
    endtask

    task automatic cmp2(input logic [1:0] act, input logic [1:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // expected outputs for effective settings c, live pwr, blocked by reset
    task automatic check_out(input logic [6:0] c, input logic pwr, input logic blk,
                             input string ctx);
        logic oe_n, od, pu, pd, d;
        logic [1:0] drv, ep, ed, epd;
        logic er, er_def;
        {oe_n, od, drv, pu, pd, d} = c;
        if (oe_n || !pwr || blk) ep = 2'b00;
        else if (!d)             ep = 2'b01;
        else if (od)             ep = 2'b00;
        else                     ep = 2'b10;
        ed  = (ep != 2'b00) ? drv : 2'b00;
        epd = {pu, pd};
        er_def = 1'b1;
        er = 1'b0;
        if (ep == 2'b10)           er = 1'b1;
        else if (ep == 2'b01)      er = 1'b0;
        else if (pu && !pd)        er = 1'b1;
        else if (pd && !pu)        er = 1'b0;
        else                       er_def = 1'b0;
        cmp2(pad_state, ep, {"R1 R2 pad_state ", ctx});
        cmp2(drv_eff, ed, {"R3 drv_eff ", ctx});
        cmp2(pull_dir, epd, {"R4 pull_dir ", ctx});
        cmp2({1'b0, pull_conflict}, {1'b0, pu & pd}, {"R5 pull_conflict ", ctx});
        if (er_def) cmp2({1'b0, core_din}, {1'b0, er}, {"R10 core_din ", ctx});
    endtask

    initial begin
        ret_stb = 1'b0;
        apply(7'b0_0_11_10_1, 1'b1);
        // R8: reset floats the driver, pulls still live
        repeat (2) @(negedge clk);
        #1 check_out(7'b0_0_11_10_1, 1'b1, 1'b1, "R8 in reset");
        apply(7'b0_0_01_01_0, 1'b1);
        #1 check_out(7'b0_0_01_01_0, 1'b1, 1'b1, "R8 in reset pulldown");
        rst_n = 1'b1;
        #1 check_out(7'b0_0_01_01_0, 1'b1, 1'b1, "R8 first cycle after release");
        @(negedge clk);
        #1 check_out(7'b0_0_01_01_0, 1'b1, 1'b0, "R8 after release drives");

        // exhaustive live sweep: R1 R2 R3 R4 R5 R10
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            apply(i[6:0], i[7]);
            #1 check_out(i[6:0], i[7], 1'b0, "live sweep");
        end

        // R6 capture of setting A, then opposite live inputs B
        @(negedge clk);
        apply(7'b0_0_10_10_1, 1'b1);
        ret_stb = 1'b1;
        @(negedge clk);
        apply(7'b1_1_01_01_0, 1'b1);
        #1 check_out(7'b0_0_10_10_1, 1'b1, 1'b0, "R6 held, inputs changed");
        @(negedge clk);
        apply(7'b0_1_11_11_0, 1'b1);
        #1 check_out(7'b0_0_10_10_1, 1'b1, 1'b0, "R6 held, second change");
        // R7: live power enable during hold
        pwr_oe = 1'b0;
        #1 check_out(7'b0_0_10_10_1, 1'b0, 1'b0, "R7 pwr_oe low in hold");
        @(negedge clk);
        pwr_oe = 1'b1;
        #1 check_out(7'b0_0_10_10_1, 1'b1, 1'b0, "R7 pwr_oe back in hold");
        // R9: strobe low, still held until the next edge
        apply(7'b0_1_01_01_0, 1'b1);
        ret_stb = 1'b0;
        #1 check_out(7'b0_0_10_10_1, 1'b1, 1'b0, "R9 before edge");
        @(negedge clk);
        #1 check_out(7'b0_1_01_01_0, 1'b1, 1'b0, "R9 live again");

        // R6 with open-drain high captured, then pulldown-only live
        @(negedge clk);
        apply(7'b0_1_11_10_1, 1'b1);
        ret_stb = 1'b1;
        @(negedge clk);
        apply(7'b0_0_00_01_1, 1'b1);
        #1 check_out(7'b0_1_11_10_1, 1'b1, 1'b0, "R6 held open-drain");
        @(negedge clk);
        ret_stb = 1'b0;
        @(negedge clk);
        #1 check_out(7'b0_0_00_01_1, 1'b1, 1'b0, "R9 live after second hold");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule